// File: doc/BRIEF.md
# Protected Power Control Register

This block holds the power-management control byte of a small controller. The byte carries a two-bit external interrupt sense field, a three-bit sleep mode selector, a sleep enable bit, and one guarded bit that asks for the brown-out detector to be switched off while the part sleeps. Software may write the ordinary fields at any time. The guarded bit can be set only inside a short change window. A signature write to a separate protection register opens that window. Clearing the guarded bit needs no unlock.

Each bus cycle stands for one instruction cycle. On a sleep-entry strobe, with sleep enabled and the guarded bit set, the block raises a brown-out-disable output to the power controller. A wake event clears both the guarded bit and that output on the same clock edge. Both registers can be read back over the bus.

Top module: `prot_ctrl_unit`

## Requirements
- R1: A write of 8'hD8 to the protection register (bus_addr=0) opens the change window for the next four cycles. Reading the protection register returns 8'h01 while the window is open and 8'h00 otherwise.
- R2: A write to the control register (bus_addr=1) with bit 4 set sets the guarded bit only while the window is open. Outside the window the guarded bit keeps its value. Bits 7:6, 3:1 and 0 still take the written value.
- R3: A control write with bit 4 clear clears the guarded bit at any time, with no unlock.
- R4: wake_evt clears the guarded bit and bod_off on the same edge. It takes priority over a protected set in the same cycle and leaves the other fields untouched.
- R5: bod_off rises only on a sleep_req cycle in which sleep enable (bit 0) and the guarded bit are already 1. It stays high until wake or until the guarded bit is cleared.
- R6: Bit 5 of the control register always reads 0 and ignores writes.
- R7: The control register layout is: sense control in bits 7:6, the guarded bit in bit 4, sleep mode in bits 3:1, sleep enable in bit 0.
- R8: After reset both registers read 8'h00 and bod_off is 0.
- R9: Writing any value other than 8'hD8 to the protection register closes the window. Any control write made while the window is open also closes it.
- R10: A further signature write while the window is open reloads the full four-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | 0 selects the protection register, 1 the control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| sleep_req | input | 1 | Sleep-entry strobe |
| wake_evt | input | 1 | Wake event |
| bod_off | output | 1 | Brown-out detector disable to the power controller |

## Verification
Two events can land in the same cycle: a wake event and a protected write that sets the guarded bit. The bench provokes this by opening the window and then presenting the setting write with wake_evt high in the same cycle. It expects the guarded bit to read 0, the ordinary fields to hold the written value, and the window to be consumed. A second collision drives sleep_req and wake_evt together while the guarded bit is set, and bod_off must stay low.

// File: rtl/pcu_pkg.sv
// Package: shared layout of the power control byte and bus address codes.
// Assumes an 8-bit control register; the field order is fixed because the
// power controller decodes it.
package pcu_pkg;
    localparam int CTRL_W = 8;

    typedef struct packed {
        logic [1:0] isc;     // external interrupt sense
        logic       rsvd;    // reserved, reads zero
        logic       bods;    // guarded brown-out-off-in-sleep request
        logic [2:0] smode;   // sleep mode select
        logic       se;      // sleep enable
    } ctrl_fields_t;

    localparam logic ADDR_PROT = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/pcu_unlock_timer.sv
// Module: change-window timer.
// Opens a window of WINDOW_CYCLES cycles after a signature write; closes it on
// a wrong protection write or when a control write consumes it.
// Assumes prot_wr and ctrl_wr are never high in the same cycle.
module pcu_unlock_timer #(
    parameter int           WINDOW_CYCLES = 4,
    parameter logic [7:0]   SIGNATURE     = 8'hD8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prot_wr,
    input  logic [7:0] prot_wdata,
    input  logic       ctrl_wr,
    output logic       win_open
);
    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             sig_hit;

    assign sig_hit  = prot_wr && (prot_wdata == SIGNATURE);
    assign win_open = (cnt_q != '0);

    // Purpose: reload, close or count down the window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sig_hit) begin
            cnt_q <= CNT_LOAD;
        end else if (prot_wr || (ctrl_wr && win_open)) begin
            cnt_q <= '0;
        end else if (win_open) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_window_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sig_hit |=> win_open);
    assert_window_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);
    assert_wrong_sig_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !sig_hit) |=> !win_open);
    assert_consumed_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && win_open) |=> !win_open);
endmodule

// File: rtl/pcu_ctrl_reg.sv
// Module: control register fields with a guarded bit.
// Ordinary fields load on any control write. The guarded bit sets only while
// the window is open, clears freely, and clears on wake (wake has priority).
// Exposes the next guarded-bit value so the output gate follows it on the same edge.
module pcu_ctrl_reg
    import pcu_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  ctrl_fields_t wfields,
    input  logic         win_open,
    input  logic         wake_evt,
    output ctrl_fields_t fields_q,
    output logic         bods_d
);
    // Purpose: next value of the guarded bit.
    always_comb begin
        bods_d = fields_q.bods;
        if (wake_evt)
            bods_d = 1'b0;
        else if (ctrl_wr && !wfields.bods)
            bods_d = 1'b0;
        else if (ctrl_wr && wfields.bods && win_open)
            bods_d = 1'b1;
    end

    // Purpose: register all fields; the reserved bit is held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else begin
            if (ctrl_wr) begin
                fields_q.isc   <= wfields.isc;
                fields_q.smode <= wfields.smode;
                fields_q.se    <= wfields.se;
            end
            fields_q.rsvd <= 1'b0;
            fields_q.bods <= bods_d;
        end
    end

    assert_bods_needs_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fields_q.bods) |-> $past(win_open && ctrl_wr));
    assert_bods_clear_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wfields.bods) |=> !fields_q.bods);
    assert_wake_clears_bods_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !fields_q.bods);
    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fields_q.rsvd);
endmodule

// File: rtl/pcu_bod_gate.sv
// Module: brown-out-disable output register.
// Sets on sleep entry (strobe with sleep enable) while the guarded bit is set,
// and drops on the same edge on which the guarded bit is cleared.
module pcu_bod_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic sleep_en,
    input  logic bods_q,
    input  logic bods_d,
    input  logic wake_evt,
    output logic bod_off
);
    logic sleep_entry;
    assign sleep_entry = sleep_req && sleep_en;

    // Purpose: hold the disable request from sleep entry until the bit clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bod_off <= 1'b0;
        else
            bod_off <= bods_d && (bod_off || (sleep_entry && bods_q));
    end

    assert_bod_needs_bods_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bod_off |-> bods_q);
    assert_bod_rise_on_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bod_off) |-> $past(sleep_req && sleep_en && bods_q));
    assert_wake_drops_bod_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !bod_off);
endmodule

// File: rtl/prot_ctrl_unit.sv
// Module: protected power control register unit (top).
// Decodes a two-register bus (protection and control), ties the window timer,
// the control fields and the brown-out-disable gate together, and muxes reads.
// Assumes one bus write per cycle; reads are combinational on bus_addr.
module prot_ctrl_unit
    import pcu_pkg::*;
#(
    parameter int         WINDOW_CYCLES = 4,
    parameter logic [7:0] SIGNATURE     = 8'hD8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        sleep_req,
    input  logic        wake_evt,
    output logic        bod_off
);
    logic         prot_wr;
    logic         ctrl_wr;
    logic         win_open;
    logic         bods_d;
    ctrl_fields_t wfields;
    ctrl_fields_t fields_q;

    assign prot_wr = bus_wr && (bus_addr == ADDR_PROT);
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign wfields = ctrl_fields_t'(bus_wdata);

    pcu_unlock_timer #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .SIGNATURE     (SIGNATURE)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .prot_wr    (prot_wr),
        .prot_wdata (bus_wdata),
        .ctrl_wr    (ctrl_wr),
        .win_open   (win_open)
    );

    pcu_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wfields  (wfields),
        .win_open (win_open),
        .wake_evt (wake_evt),
        .fields_q (fields_q),
        .bods_d   (bods_d)
    );

    pcu_bod_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .sleep_en  (fields_q.se),
        .bods_q    (fields_q.bods),
        .bods_d    (bods_d),
        .wake_evt  (wake_evt),
        .bod_off   (bod_off)
    );

    // Purpose: select the read-back value of the addressed register.
    always_comb begin
        if (bus_addr == ADDR_PROT)
            bus_rdata = {7'b0, win_open};
        else
            bus_rdata = fields_q;
    end

    assert_rsvd_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[5] == 1'b0));
    assert_prot_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_PROT) |-> (bus_rdata[7:1] == 7'b0));
endmodule

// File: tb/prot_ctrl_unit_tb.sv
`timescale 1ns/1ps
module prot_ctrl_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       bod_off;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    localparam logic [7:0] SIG = 8'hD8;

    always #2.5 clk = ~clk;

    prot_ctrl_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .wake_evt(wake_evt), .bod_off(bod_off)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one clock edge, then settle at the falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
    endtask

    initial begin
        logic [7:0] r;
        @(negedge clk);
        idle(2);
        rst_n = 1'b1;
        // R8 reset state
        rd(1'b0, r); check("R8 prot reset", r, 8'h00);
        rd(1'b1, r); check("R8 ctrl reset", r, 8'h00);
        check("R8 bod_off reset", {7'b0, bod_off}, 8'h00);

        // R1 window length as seen on the protection read
        wr(1'b0, SIG);
        for (int k = 0; k < 6; k++) begin
            rd(1'b0, r);
            check("R1 window read", r, (k < 4) ? 8'h01 : 8'h00);
            idle(1);
        end

        // R1/R2 set attempt after d idle cycles
        for (int d = 0; d < 7; d++) begin
            clear_all();
            wr(1'b0, SIG);
            idle(d);
            wr(1'b1, 8'h10);
            rd(1'b1, r);
            check("R2 timed set", r, (d <= 3) ? 8'h10 : 8'h00);
            rd(1'b0, r);
            check("R9 window consumed", r, 8'h00);
        end

        // R2 R6 R7: every value written outside the window
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, 8'h00);
            wr(1'b1, 8'(v));
            rd(1'b1, r);
            check("R2 R6 R7 outside window", r, 8'(v) & 8'hCF);
        end
        // R2 R6 R7: every value written inside the window
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, 8'h00);
            wr(1'b0, SIG);
            wr(1'b1, 8'(v));
            rd(1'b1, r);
            check("R2 R6 R7 inside window", r, 8'(v) & 8'hDF);
        end

        // R3 clearing needs no unlock
        clear_all();
        wr(1'b0, SIG); wr(1'b1, 8'h1A);
        wr(1'b1, 8'h0A);
        rd(1'b1, r); check("R3 free clear", r, 8'h0A);

        // R9 wrong signature closes the window
        clear_all();
        wr(1'b0, SIG); wr(1'b0, 8'hD9);
        rd(1'b0, r); check("R9 wrong sig closes", r, 8'h00);
        wr(1'b1, 8'h10);
        rd(1'b1, r); check("R9 set after wrong sig", r, 8'h00);
        // R9 a control write without bit 4 consumes the window
        wr(1'b0, SIG); wr(1'b1, 8'h01); wr(1'b1, 8'h11);
        rd(1'b1, r); check("R9 second write blocked", r, 8'h01);

        // R10 reload
        clear_all();
        wr(1'b0, SIG); idle(3); wr(1'b0, SIG); idle(3);
        wr(1'b1, 8'h10);
        rd(1'b1, r); check("R10 reload", r, 8'h10);

        // R5 sleep entry with bit set and sleep enabled
        clear_all();
        wr(1'b0, SIG); wr(1'b1, 8'h13);
        check("R5 no sleep yet", {7'b0, bod_off}, 8'h00);
        sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
        check("R5 bod_off on sleep", {7'b0, bod_off}, 8'h01);
        idle(2);
        check("R5 bod_off held", {7'b0, bod_off}, 8'h01);
        // R4 wake clears bit and output, other fields kept
        wake_evt = 1'b1; cyc(); wake_evt = 1'b0;
        check("R4 wake drops bod_off", {7'b0, bod_off}, 8'h00);
        rd(1'b1, r); check("R4 wake clears bit", r, 8'h03);

        // R5 sleep enable clear blocks the output
        clear_all();
        wr(1'b0, SIG); wr(1'b1, 8'h12);
        sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
        check("R5 no bod_off without enable", {7'b0, bod_off}, 8'h00);
        // R5 bit clear blocks the output
        wr(1'b1, 8'h01);
        sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
        check("R5 no bod_off without bit", {7'b0, bod_off}, 8'h00);
        // R5 software clear drops the output
        wr(1'b0, SIG); wr(1'b1, 8'h11);
        sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
        check("R5 bod_off set again", {7'b0, bod_off}, 8'h01);
        wr(1'b1, 8'h01);
        check("R5 software clear drops bod_off", {7'b0, bod_off}, 8'h00);

        // R4 wake collides with a protected set
        clear_all();
        wr(1'b0, SIG);
        wake_evt = 1'b1; wr(1'b1, 8'h15); wake_evt = 1'b0;
        rd(1'b1, r); check("R4 wake beats set", r, 8'h05);
        rd(1'b0, r); check("R4 window consumed", r, 8'h00);
        // R4 wake collides with sleep entry
        wr(1'b0, SIG); wr(1'b1, 8'h11);
        sleep_req = 1'b1; wake_evt = 1'b1; cyc();
        sleep_req = 1'b0; wake_evt = 1'b0;
        check("R4 wake beats sleep", {7'b0, bod_off}, 8'h00);
        rd(1'b1, r); check("R4 bit cleared", r, 8'h01);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule